// File: doc/BRIEF.md
# Double-Buffered DMA Transfer Counter Bank

This block holds the transfer counts for four DMA channels. Each channel has two 16-bit stages. The first is a master stage that the CPU writes and reads. The second is a working stage that the DMA engine counts down, one step per completed transfer. When a channel starts, the master value is copied into the working stage. Software can then write the count for the next run into the master stage while the current run is still counting.

The count is biased by one. A loaded value N yields N+1 transfers, and the run ends on the transfer that would take the working count below zero. That transfer raises a one-cycle terminal-count pulse and returns the channel to idle. While a channel runs, a CPU read returns the remaining count. While it is idle, a read returns the master stage. So after a run ends, and provided software has not written the channel since, a read shows the value that was loaded and not zero.

Top module: `dma_count_bank`

## Requirements
- R1: Writing `cpuWrData` with `cpuWrEn` high stores the whole 16-bit word into the master stage of the channel chosen by `cpuSel` (0 to 3). With that channel idle, the next read of that channel returns the written word.
- R2: A `startReq` pulse on an idle channel copies its master stage into the working stage and makes the channel active. From the next cycle on, a read of that channel returns the working count.
- R3: Each `xferDone` pulse on an active channel whose working count is nonzero lowers that count by exactly one.
- R4: An `xferDone` pulse on an active channel whose working count is 0000H ends the run. `tcPulse` for that channel is high for exactly the one following cycle, and the channel becomes idle. A loaded N therefore yields N+1 transfers: 0000H gives 1 and FFFFH gives 65,536.
- R5: A write during a run changes only the master stage. Reads still return the remaining count until the run ends, then return the new value, and the next start loads the new value.
- R6: After terminal count with no write since, a read returns the value loaded for that run, not 0000H.
- R7: A CPU write and an `xferDone` pulse on the same channel in the same cycle both take effect: the master stage takes the write and the working count steps down.
- R8: `xferDone` pulses on an idle channel change neither its readable count nor `tcPulse`.
- R9: A `startReq` pulse on an already active channel is ignored, and the working count is not reloaded.
- R10: A `startReq` pulse and a CPU write to the same idle channel in the same cycle load the previous master value into the working stage. The written value stays in the master stage.
- R11: Channels are independent: strobes on one channel never change another channel's count or terminal-count pulse.
- R12: After reset every channel is idle and `tcPulse` is all zero. Count contents are undefined until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 2 | Channel selected for CPU read and write |
| cpuWrEn | input | 1 | CPU write strobe for the selected channel |
| cpuWrData | input | 16 | CPU write data |
| cpuRdData | output | 16 | Readable count of the selected channel (combinational) |
| startReq | input | 4 | Per-channel start or reload request |
| xferDone | input | 4 | Per-channel completed-transfer pulse from the DMA engine |
| tcPulse | output | 4 | Per-channel one-cycle terminal-count pulse |

## Verification
The bench builds the block with its default parameters: four channels and a 16-bit count. It sweeps small loaded counts across every channel and counts the transfers arithmetically, checking the read value after each step. The full-width load of FFFFH is driven through to its 65,536th transfer, so the borrow at the top of the range is checked directly rather than only at a reduced width. It also drives same-cycle write/decrement and write/start collisions, starts on active channels, and done pulses on idle channels.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic load;      // copy master stage into working stage
    logic dec;       // step working count down by one
    logic showWork;  // reads return working stage instead of master
  } chStrobe_t;
endpackage

// File: rtl/dma_cnt_ctrl.sv
module dma_cnt_ctrl
  import dma_cnt_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      startReq,
  input  logic [NUM_CH-1:0]      xferDone,
  input  logic [NUM_CH-1:0]      workZero,
  output chStrobe_t [NUM_CH-1:0] stb,
  output logic [NUM_CH-1:0]      chActive,
  output logic [NUM_CH-1:0]      tcPulse
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic activeQ;
    logic tcQ;
    logic loadNow;
    logic lastXfer;

    always_comb begin
      loadNow  = startReq[ch] & ~activeQ;
      lastXfer = xferDone[ch] & activeQ & workZero[ch];
      stb[ch].load     = loadNow;
      stb[ch].dec      = xferDone[ch] & activeQ & ~workZero[ch];
      stb[ch].showWork = activeQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeQ <= 1'b0;
        tcQ     <= 1'b0;
      end else begin
        tcQ <= lastXfer;
        if (loadNow)       activeQ <= 1'b1;
        else if (lastXfer) activeQ <= 1'b0;
      end
    end

    assign chActive[ch] = activeQ;
    assign tcPulse[ch]  = tcQ;
  end

endmodule

// File: rtl/dma_cnt_path.sv
module dma_cnt_path
  import dma_cnt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 2
) (
  input  logic                   clk,
  input  logic [SEL_W-1:0]       cpuSel,
  input  logic                   cpuWrEn,
  input  logic [CNT_W-1:0]       cpuWrData,
  input  chStrobe_t [NUM_CH-1:0] stb,
  output logic [CNT_W-1:0]       cpuRdData,
  output logic [NUM_CH-1:0]      workZero
);

  logic [CNT_W-1:0] masterQ [NUM_CH];
  logic [CNT_W-1:0] workQ   [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_stage
    logic wrHit;
    assign wrHit = cpuWrEn && (cpuSel == SEL_W'(ch));

    // Count stages are not reset: contents are undefined until written
    always_ff @(posedge clk) begin
      if (wrHit) masterQ[ch] <= cpuWrData;
      if (stb[ch].load)     workQ[ch] <= masterQ[ch];
      else if (stb[ch].dec) workQ[ch] <= workQ[ch] - CNT_W'(1);
    end

    assign workZero[ch] = (workQ[ch] == '0);
  end

  always_comb begin
    cpuRdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (cpuSel == SEL_W'(ch))
        cpuRdData = stb[ch].showWork ? workQ[ch] : masterQ[ch];
    end
  end

endmodule

// File: rtl/dma_count_bank.sv
module dma_count_bank
  import dma_cnt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  cpuSel,
  input  logic              cpuWrEn,
  input  logic [CNT_W-1:0]  cpuWrData,
  output logic [CNT_W-1:0]  cpuRdData,
  input  logic [NUM_CH-1:0] startReq,
  input  logic [NUM_CH-1:0] xferDone,
  output logic [NUM_CH-1:0] tcPulse
);

  chStrobe_t [NUM_CH-1:0] stb;
  logic [NUM_CH-1:0]      workZero;
  logic [NUM_CH-1:0]      chActive;

  dma_cnt_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .xferDone (xferDone),
    .workZero (workZero),
    .stb      (stb),
    .chActive (chActive),
    .tcPulse  (tcPulse)
  );

  dma_cnt_path #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_path (
    .clk       (clk),
    .cpuSel    (cpuSel),
    .cpuWrEn   (cpuWrEn),
    .cpuWrData (cpuWrData),
    .stb       (stb),
    .cpuRdData (cpuRdData),
    .workZero  (workZero)
  );

endmodule

// File: rtl/dma_count_bank_chk.sv
module dma_count_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [SEL_W-1:0]  cpuSel,
  input logic              cpuWrEn,
  input logic [CNT_W-1:0]  cpuWrData,
  input logic [CNT_W-1:0]  cpuRdData,
  input logic [NUM_CH-1:0] startReq,
  input logic [NUM_CH-1:0] xferDone,
  input logic [NUM_CH-1:0] tcPulse,
  input logic [NUM_CH-1:0] chActive
);

  p_write_visible_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !chActive[cpuSel] && !startReq[cpuSel])
      |=> (!$stable(cpuSel) || cpuRdData == $past(cpuWrData)));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chActive[cpuSel] && xferDone[cpuSel] && cpuRdData != '0)
      |=> (!$stable(cpuSel) || cpuRdData == $past(cpuRdData) - CNT_W'(1)));

  p_borrow_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chActive[cpuSel] && xferDone[cpuSel] && cpuRdData == '0)
      |=> tcPulse[$past(cpuSel)]);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!chActive[cpuSel] && !cpuWrEn && !startReq[cpuSel])
      |=> (!$stable(cpuSel) || $stable(cpuRdData)));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tc
    p_tc_single_r4: assert property (@(posedge clk) disable iff (!rstN)
      tcPulse[ch] |=> !tcPulse[ch]);
    p_tc_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
      tcPulse[ch] |-> ($past(xferDone[ch]) && !chActive[ch]));
  end

endmodule

bind dma_count_bank dma_count_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuSel    (cpuSel),
  .cpuWrEn   (cpuWrEn),
  .cpuWrData (cpuWrData),
  .cpuRdData (cpuRdData),
  .startReq  (startReq),
  .xferDone  (xferDone),
  .tcPulse   (tcPulse),
  .chActive  (chActive)
);

// File: tb/dma_count_bank_test.sv
module dma_count_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       cpuSel;
  logic             cpuWrEn;
  logic [CNT_W-1:0] cpuWrData;
  logic [CNT_W-1:0] cpuRdData;
  logic [3:0]       startReq;
  logic [3:0]       xferDone;
  logic [3:0]       tcPulse;

  int errCount = 0;
  int chkCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_count_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWrEn(cpuWrEn),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .startReq(startReq),
    .xferDone(xferDone), .tcPulse(tcPulse)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    chkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wrCnt(input int ch, input int val);
    cpuSel = 2'(ch); cpuWrData = 16'(val); cpuWrEn = 1'b1;
    tick();
    cpuWrEn = 1'b0;
  endtask

  task automatic rdCnt(input int ch, output int val);
    cpuSel = 2'(ch);
    #1;
    val = int'(cpuRdData);
  endtask

  task automatic startCh(input int ch);
    startReq[ch] = 1'b1;
    tick();
    startReq[ch] = 1'b0;
  endtask

  // Hold done high until tc appears; expect loaded+1 transfers
  task automatic runToTc(input int ch, input int loaded, input bit eachStep, input string tag);
    int cnt = 0;
    int v;
    xferDone[ch] = 1'b1;
    forever begin
      tick();
      cnt++;
      if (tcPulse[ch] || cnt > loaded + 2) break;
      if (eachStep) begin
        rdCnt(ch, v);
        check(v == loaded - cnt, {tag, " R3 remaining"}, v, loaded - cnt);
      end
    end
    xferDone[ch] = 1'b0;
    check(cnt == loaded + 1, {tag, " R4 transfer count"}, cnt, loaded + 1);
    tick();
    check(tcPulse[ch] == 1'b0, {tag, " R4 tc single cycle"}, tcPulse[ch], 0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int v;
    rstN = 1'b0; cpuSel = '0; cpuWrEn = 1'b0; cpuWrData = '0;
    startReq = '0; xferDone = '0;
    repeat (3) tick();
    check(tcPulse == 4'b0, "R12 reset tc", tcPulse, 0);
    rstN = 1'b1;
    tick();
    check(tcPulse == 4'b0, "R12 after release", tcPulse, 0);

    // R1: whole-word write and idle read on every channel
    for (int ch = 0; ch < NUM_CH; ch++) wrCnt(ch, 16'hA5C0 + ch * 16'h0111);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      rdCnt(ch, v);
      check(v == 16'hA5C0 + ch * 16'h0111, "R1 readback", v, 16'hA5C0 + ch * 16'h0111);
    end

    // Sweep small counts on every channel: R2, R3, R4, R6
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int n = 0; n < 8; n++) begin
        wrCnt(ch, n);
        startCh(ch);
        rdCnt(ch, v);
        check(v == n, "R2 loaded into working", v, n);
        runToTc(ch, n, 1'b1, "sweep");
        rdCnt(ch, v);
        check(v == n, "R6 read after tc", v, n);
      end
    end

    // Full range: FFFFH gives 65,536 transfers (R4)
    wrCnt(2, 16'hFFFF);
    startCh(2);
    runToTc(2, 65535, 1'b0, "full");
    rdCnt(2, v);
    check(v == 16'hFFFF, "R6 read after full run", v, 16'hFFFF);

    // R5: write during a run
    wrCnt(1, 5);
    startCh(1);
    xferDone[1] = 1'b1; tick(); tick(); xferDone[1] = 1'b0;
    wrCnt(1, 9);
    rdCnt(1, v);
    check(v == 3, "R5 remaining unchanged by write", v, 3);
    runToTc(1, 3, 1'b1, "R5");
    rdCnt(1, v);
    check(v == 9, "R5 new master after end", v, 9);
    startCh(1);
    rdCnt(1, v);
    check(v == 9, "R5 next start uses new value", v, 9);
    runToTc(1, 9, 1'b0, "R5b");

    // R7: write and done in the same cycle
    wrCnt(3, 4);
    startCh(3);
    cpuSel = 2'd3; cpuWrData = 16'd20; cpuWrEn = 1'b1; xferDone[3] = 1'b1;
    tick();
    cpuWrEn = 1'b0; xferDone[3] = 1'b0;
    rdCnt(3, v);
    check(v == 3, "R7 decrement kept", v, 3);
    runToTc(3, 3, 1'b0, "R7");
    rdCnt(3, v);
    check(v == 20, "R7 write kept", v, 20);

    // R8: done pulses on an idle channel
    wrCnt(0, 12);
    xferDone[0] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(tcPulse[0] == 1'b0, "R8 no tc while idle", tcPulse[0], 0);
    end
    xferDone[0] = 1'b0;
    rdCnt(0, v);
    check(v == 12, "R8 idle count untouched", v, 12);

    // R9: start on an active channel
    startCh(0);
    xferDone[0] = 1'b1; tick(); tick(); xferDone[0] = 1'b0;
    startCh(0);
    rdCnt(0, v);
    check(v == 10, "R9 no reload while active", v, 10);
    runToTc(0, 10, 1'b0, "R9");

    // R10: start and write in the same cycle
    wrCnt(2, 6);
    cpuSel = 2'd2; cpuWrData = 16'd11; cpuWrEn = 1'b1; startReq[2] = 1'b1;
    tick();
    cpuWrEn = 1'b0; startReq[2] = 1'b0;
    rdCnt(2, v);
    check(v == 6, "R10 old master loaded", v, 6);
    runToTc(2, 6, 1'b0, "R10");
    rdCnt(2, v);
    check(v == 11, "R10 write kept in master", v, 11);

    // R11: independence
    wrCnt(1, 3);
    wrCnt(2, 8);
    startReq = 4'b0110; tick(); startReq = '0;
    xferDone[1] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(tcPulse[2] == 1'b0 && tcPulse[0] == 1'b0 && tcPulse[3] == 1'b0,
            "R11 other tc quiet", tcPulse, 4'b0010 & tcPulse);
    end
    xferDone[1] = 1'b0;
    rdCnt(2, v);
    check(v == 8, "R11 other count untouched", v, 8);
    runToTc(2, 8, 1'b0, "R11");

    finishRun();
  end

endmodule